// File: doc/BRIEF.md
# Multi-Dimensional DMA Address Generator

This block sequences the addresses for a single DMA channel. A parameter set is loaded with one strobe. It holds an options field, source and destination start addresses, a count word, an index word, an element-count reload value and a 16-bit link offset. The count word has the frame count in its upper half and the element count in its lower half. The index word has the frame index in its upper half and the element index in its lower half.

Each synchronisation event starts a burst of source/destination address pairs, each with an element size in bytes. A burst is one element, one frame or the whole block, depending on the dimension and sync bits. Each pair is held on a valid/ready handshake until it is accepted.

When the block ends, a one-cycle completion pulse is raised. If linking is enabled, the generator then requests the next parameter set from the address formed by the link offset under a fixed upper base. It reloads from the returned set and re-arms itself.

Top module: `dma_addr_seq`

## Requirements
- R1: After reset no pair is offered, `done` and `lnk_req` are low, and a sync event has no effect until a parameter set is loaded with `cfg_load`.
- R2: `p_opt[3:2]` selects the element size: 00 gives `out_size`=4, 01 gives 2, 10 gives 1, and the reserved code 11 is treated as 4.
- R3: The source mode is `p_opt[5:4]` and the destination mode is `p_opt[7:6]`. Code 00 keeps the address fixed, including across frames. Code 01 adds the element size per element and code 10 subtracts it. Code 11 adds the sign-extended element index `p_idx[15:0]` in 1-D mode.
- R4: The element count is `p_cnt[15:0]` and the frame count is `p_cnt[31:16]`, programmed as frames minus one. The first frame has the programmed element count. Every later frame has `p_rld` elements. The block ends after the frame in which the frame count was zero.
- R5: In 1-D mode with element sync (`p_opt[1:0]`=00), each event moves one element. A new frame starts at the last element address plus the sign-extended frame index `p_idx[31:16]`. Non-fixed modes apply the frame index.
- R6: In 1-D mode with frame sync (`p_opt[1:0]`=01), each event moves one frame. The next frame starts at the first element address of the frame plus the frame index.
- R7: In 2-D mode with line sync (`p_opt[1:0]`=10), each event moves one line. The element index is ignored, so indexed mode steps by the element size. The next line starts at the first element address plus the frame index.
- R8: In 2-D mode with block sync (`p_opt[1:0]`=11), one event moves the whole block without a gap in `out_vld`. Each next line starts at the last element address plus the frame index.
- R9: While `out_vld` is high and `out_rdy` is low, the offered pair is held unchanged.
- R10: `done` is high for exactly one cycle, the cycle after the final pair of the block is accepted.
- R11: When the link bit `p_opt[8]` is set, `lnk_req` rises together with `done`, with `lnk_addr` = {LINK_BASE, link offset}. A set presented with `lnk_vld` is loaded and the channel re-arms. Without the link bit the channel returns to the unloaded state and ignores events.
- R12: Sync events arriving during a burst are dropped. A burst starts only on an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load parameter bus while not mid-burst |
| p_opt | input | 9 | Options: sync, dimension, size, source mode, destination mode, link |
| p_src | input | ADDR_W | Source start address |
| p_dst | input | ADDR_W | Destination start address |
| p_cnt | input | 32 | Frame count (high) and element count (low) |
| p_idx | input | 32 | Frame index (high) and element index (low) |
| p_rld | input | 16 | Element count for frames after the first |
| p_lnk | input | 16 | Link offset |
| lnk_vld | input | 1 | Linked parameter set present on the bus |
| sync_ev | input | 1 | Synchronisation event |
| out_vld | output | 1 | Address pair valid |
| out_rdy | input | 1 | Address pair accepted |
| out_src | output | ADDR_W | Source element address |
| out_dst | output | ADDR_W | Destination element address |
| out_size | output | 3 | Element size in bytes |
| done | output | 1 | Block complete pulse |
| lnk_req | output | 1 | Request for linked parameter set |
| lnk_addr | output | ADDR_W | Address of linked parameter set |

## Verification
The bench builds the generator with 32-bit addresses and a link base of 16'h5A00. This lets the link address check tell the programmed offset apart from the fixed upper half. With full-width addresses, negative frame indices and decrementing modes wrap exactly as a 32-bit bus would. Small element and frame counts keep every block short, so each of the four sync orderings can be run to completion. Those runs include a reload count that differs from the first-frame count and a chained block fetched through the link path.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int FLD_W = 16;
  localparam int OFF_W = 32;

  typedef enum logic [1:0] {
    AM_FIXED = 2'd0,
    AM_INC   = 2'd1,
    AM_DEC   = 2'd2,
    AM_INDEX = 2'd3
  } addr_mode_e;

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_RUN, ST_LINK} seq_state_e;

  typedef enum logic [1:0] {BK_ELEM, BK_LINE, BK_BLOCK} burst_e;

  typedef struct packed {
    logic       link_en;
    addr_mode_e dmode;
    addr_mode_e smode;
    logic [1:0] esize;
    logic       two_d;
    logic       whole;
  } opt_t;

  // element size code to byte count; reserved code falls back to 4 bytes
  function automatic logic [2:0] size_bytes(input logic [1:0] es);
    case (es)
      2'b01:   return 3'd2;
      2'b10:   return 3'd1;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic signed [OFF_W-1:0] sext_fld(input logic [FLD_W-1:0] v);
    return {{(OFF_W-FLD_W){v[FLD_W-1]}}, v};
  endfunction

  // step applied between two elements of one frame
  function automatic logic signed [OFF_W-1:0] elem_off(input addr_mode_e m, input logic two_d,
                                                       input logic [2:0] b,
                                                       input logic [FLD_W-1:0] ei);
    logic signed [OFF_W-1:0] bs;
    bs = {{(OFF_W-3){1'b0}}, b};
    case (m)
      AM_FIXED: return '0;
      AM_INC:   return bs;
      AM_DEC:   return -bs;
      default:  return two_d ? bs : sext_fld(ei);
    endcase
  endfunction

  // step applied at a frame boundary
  function automatic logic signed [OFF_W-1:0] frame_off(input addr_mode_e m,
                                                        input logic [FLD_W-1:0] fi);
    return (m == AM_FIXED) ? '0 : sext_fld(fi);
  endfunction

  // next frame grows from the last element in 1-D element sync and 2-D block sync
  function automatic logic from_last(input logic whole, input logic two_d);
    return whole == two_d;
  endfunction

  function automatic burst_e burst_kind(input logic whole, input logic two_d);
    if (!two_d && !whole) return BK_ELEM;
    if (two_d && whole)   return BK_BLOCK;
    return BK_LINE;
  endfunction
endpackage

// File: rtl/dma_addr_side.sv
module dma_addr_side
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              elem_adv,
  input  logic              frm_adv,
  input  logic [ADDR_W-1:0] start,
  input  addr_mode_e        mode,
  input  logic              two_d,
  input  logic              last_base,
  input  logic [2:0]        bytes,
  input  logic [FLD_W-1:0]  eidx,
  input  logic [FLD_W-1:0]  fidx,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] first_q;
  logic [ADDR_W-1:0] estep;
  logic [ADDR_W-1:0] fstep;
  logic [ADDR_W-1:0] frm_base;
  logic [ADDR_W-1:0] frm_next;
  logic signed [OFF_W-1:0] eoff;
  logic signed [OFF_W-1:0] foff;

  assign eoff     = elem_off(mode, two_d, bytes, eidx);
  assign foff     = frame_off(mode, fidx);
  assign estep    = ADDR_W'(eoff);
  assign fstep    = ADDR_W'(foff);
  assign frm_base = last_base ? addr : first_q;
  assign frm_next = frm_base + fstep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr    <= '0;
      first_q <= '0;
    end else if (load) begin
      addr    <= start;
      first_q <= start;
    end else if (frm_adv) begin
      addr    <= frm_next;
      first_q <= frm_next;
    end else if (elem_adv) begin
      addr    <= addr + estep;
    end
  end

  a_r3_fixed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_adv && !load && mode == AM_FIXED) |=> $stable(addr));
endmodule

// File: rtl/dma_seq_ctl.sv
module dma_seq_ctl
  import dma_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic             lnk_vld,
  input  logic             sync_ev,
  input  logic             out_rdy,
  input  logic             whole,
  input  logic             two_d,
  input  logic             link_en,
  input  logic [FLD_W-1:0] ecnt_init,
  input  logic [FLD_W-1:0] fcnt_init,
  input  logic [FLD_W-1:0] ecnt_rld,
  output logic             out_vld,
  output logic             lnk_req,
  output logic             done,
  output logic             load_en,
  output logic             elem_adv,
  output logic             frm_adv
);
  seq_state_e st;
  logic [FLD_W-1:0] ecnt;
  logic [FLD_W-1:0] fcnt;
  burst_e unit;

  // named internal events
  logic fire;
  logic last_elem;
  logic last_frame;
  logic blk_end;
  logic burst_end;

  assign unit       = burst_kind(whole, two_d);
  assign out_vld    = (st == ST_RUN);
  assign lnk_req    = (st == ST_LINK);
  assign fire       = out_vld && out_rdy;
  assign last_elem  = (ecnt <= FLD_W'(1));
  assign last_frame = (fcnt == '0);
  assign blk_end    = fire && last_elem && last_frame;
  assign burst_end  = fire && (blk_end || unit == BK_ELEM || (last_elem && unit == BK_LINE));
  assign elem_adv   = fire && !last_elem;
  assign frm_adv    = fire && last_elem && !last_frame;
  assign load_en    = (cfg_load && (st == ST_IDLE || st == ST_ARM)) ||
                      (lnk_vld && st == ST_LINK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: if (load_en) st <= ST_ARM;
        ST_ARM:  if (!load_en && sync_ev) st <= ST_RUN;
        ST_RUN: begin
          if (blk_end)        st <= link_en ? ST_LINK : ST_IDLE;
          else if (burst_end) st <= ST_ARM;
        end
        default: if (load_en) st <= ST_ARM;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt <= '0;
      fcnt <= '0;
    end else if (load_en) begin
      ecnt <= ecnt_init;
      fcnt <= fcnt_init;
    end else if (frm_adv) begin
      ecnt <= ecnt_rld;
      fcnt <= fcnt - FLD_W'(1);
    end else if (elem_adv) begin
      ecnt <= ecnt - FLD_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= blk_end;
  end

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_vld);
  a_r5_elem_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !two_d && !whole) |=> !out_vld);
  a_r8_block_continuous: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && two_d && whole && !blk_end) |=> out_vld);
  a_r11_link_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lnk_req) |-> done);
  a_r12_start_by_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_vld) |-> $past(sync_ev));
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_seq_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-17:0] LINK_BASE = 16'h01A0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [8:0]        p_opt,
  input  logic [ADDR_W-1:0] p_src,
  input  logic [ADDR_W-1:0] p_dst,
  input  logic [31:0]       p_cnt,
  input  logic [31:0]       p_idx,
  input  logic [15:0]       p_rld,
  input  logic [15:0]       p_lnk,
  input  logic              lnk_vld,
  input  logic              sync_ev,
  output logic              out_vld,
  input  logic              out_rdy,
  output logic [ADDR_W-1:0] out_src,
  output logic [ADDR_W-1:0] out_dst,
  output logic [2:0]        out_size,
  output logic              done,
  output logic              lnk_req,
  output logic [ADDR_W-1:0] lnk_addr
);
  localparam int NSIDE = 2;

  opt_t             opt_q;
  logic [FLD_W-1:0] eidx_q;
  logic [FLD_W-1:0] fidx_q;
  logic [FLD_W-1:0] rld_q;
  logic [FLD_W-1:0] lnk_q;

  logic load_en;
  logic elem_adv;
  logic frm_adv;
  logic last_base;
  logic [2:0] bytes;

  logic [ADDR_W-1:0] side_start [NSIDE];
  addr_mode_e        side_mode  [NSIDE];
  logic [ADDR_W-1:0] side_addr  [NSIDE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt_q  <= '0;
      eidx_q <= '0;
      fidx_q <= '0;
      rld_q  <= '0;
      lnk_q  <= '0;
    end else if (load_en) begin
      opt_q  <= opt_t'(p_opt);
      eidx_q <= p_idx[FLD_W-1:0];
      fidx_q <= p_idx[2*FLD_W-1:FLD_W];
      rld_q  <= p_rld;
      lnk_q  <= p_lnk;
    end
  end

  assign bytes     = size_bytes(opt_q.esize);
  assign last_base = from_last(opt_q.whole, opt_q.two_d);

  dma_seq_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_load (cfg_load),
    .lnk_vld  (lnk_vld),
    .sync_ev  (sync_ev),
    .out_rdy  (out_rdy),
    .whole    (opt_q.whole),
    .two_d    (opt_q.two_d),
    .link_en  (opt_q.link_en),
    .ecnt_init(p_cnt[FLD_W-1:0]),
    .fcnt_init(p_cnt[2*FLD_W-1:FLD_W]),
    .ecnt_rld (rld_q),
    .out_vld  (out_vld),
    .lnk_req  (lnk_req),
    .done     (done),
    .load_en  (load_en),
    .elem_adv (elem_adv),
    .frm_adv  (frm_adv)
  );

  assign side_start[0] = p_src;
  assign side_start[1] = p_dst;
  assign side_mode[0]  = opt_q.smode;
  assign side_mode[1]  = opt_q.dmode;

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dma_addr_side #(.ADDR_W(ADDR_W)) u_side (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_en),
      .elem_adv (elem_adv),
      .frm_adv  (frm_adv),
      .start    (side_start[g]),
      .mode     (side_mode[g]),
      .two_d    (opt_q.two_d),
      .last_base(last_base),
      .bytes    (bytes),
      .eidx     (eidx_q),
      .fidx     (fidx_q),
      .addr     (side_addr[g])
    );
  end

  assign out_src  = side_addr[0];
  assign out_dst  = side_addr[1];
  assign out_size = bytes;
  assign lnk_addr = {LINK_BASE, lnk_q};

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_rdy) |=> (out_vld && $stable(out_src) && $stable(out_dst)));
  a_r2_size_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> ($countones(out_size) == 1));
endmodule

// File: tb/dma_addr_seq_test.sv
module dma_addr_seq_test;
  localparam int          AW = 32;
  localparam logic [15:0] LB = 16'h5A00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          cfg_load = 0, lnk_vld = 0, sync_ev = 0, out_rdy = 0;
  logic [8:0]    p_opt = '0;
  logic [AW-1:0] p_src = '0, p_dst = '0;
  logic [31:0]   p_cnt = '0, p_idx = '0;
  logic [15:0]   p_rld = '0, p_lnk = '0;
  logic          out_vld, done, lnk_req;
  logic [AW-1:0] out_src, out_dst, lnk_addr;
  logic [2:0]    out_size;

  dma_addr_seq #(.ADDR_W(AW), .LINK_BASE(LB)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .p_opt(p_opt), .p_src(p_src),
    .p_dst(p_dst), .p_cnt(p_cnt), .p_idx(p_idx), .p_rld(p_rld), .p_lnk(p_lnk),
    .lnk_vld(lnk_vld), .sync_ev(sync_ev), .out_vld(out_vld), .out_rdy(out_rdy),
    .out_src(out_src), .out_dst(out_dst), .out_size(out_size), .done(done),
    .lnk_req(lnk_req), .lnk_addr(lnk_addr)
  );

  int checks = 0, errors = 0, popped = 0, cyc = 0;
  bit stall = 0, finished = 0;
  logic [31:0] q_src[$], q_dst[$];
  int          q_sz[$], q_burst[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ready pattern
  initial forever begin
    @(posedge clk); #2;
    cyc++;
    out_rdy = !stall || (cyc % 3 != 0);
  end

  // monitor / scoreboard
  bit hold_pend = 0;
  logic [31:0] hs, hd;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend && out_vld)
        chk(out_src == hs && out_dst == hd, "R9 stalled pair held", {out_src, out_dst}, {hs, hd});
      hold_pend = out_vld && !out_rdy;
      hs = out_src;
      hd = out_dst;
      if (out_vld && out_rdy) begin
        if (q_src.size() == 0) chk(1'b0, "R12 unexpected pair", {32'd0, out_src}, 64'd0);
        else begin
          logic [31:0] es, ed;
          int ez;
          es = q_src.pop_front();
          ed = q_dst.pop_front();
          ez = q_sz.pop_front();
          chk(out_src == es, "R3 source address", {32'd0, out_src}, {32'd0, es});
          chk(out_dst == ed, "R3 destination address", {32'd0, out_dst}, {32'd0, ed});
          chk(int'(out_size) == ez, "R2 element size", 64'(out_size), 64'(ez));
        end
        popped++;
      end
    end
  end

  // independent address model for one side
  task automatic model_side(input logic [31:0] start, input logic [1:0] mode, input bit d2,
                            input bit whole, input int sz, input logic [15:0] ei,
                            input logic [15:0] fi, input int n0, input int rld,
                            input int frames, ref logic [31:0] q[$]);
    int step;
    bit uselast;
    logic [31:0] fs;
    if (mode == 2'd0)      step = 0;
    else if (mode == 2'd1) step = sz;
    else if (mode == 2'd2) step = -sz;
    else                   step = d2 ? sz : int'($signed(ei));
    uselast = (d2 && whole) || (!d2 && !whole);
    fs = start;
    for (int f = 0; f < frames; f++) begin
      int n;
      n = (f == 0) ? n0 : rld;
      for (int e = 0; e < n; e++) q.push_back(fs + 32'(e * step));
      if (uselast) fs = fs + 32'((n - 1) * step);
      if (mode != 2'd0) fs = fs + 32'(int'($signed(fi)));
    end
  endtask

  task automatic set_bus(input bit whole, input bit d2, input logic [1:0] es, input logic [1:0] sm,
                         input logic [1:0] dm, input bit lk, input logic [31:0] src,
                         input logic [31:0] dst, input int n, input int m1,
                         input logic [15:0] ei, input logic [15:0] fi, input int rld,
                         input logic [15:0] lnk);
    p_opt = {lk, dm, sm, es, d2, whole};
    p_src = src;
    p_dst = dst;
    p_cnt = {16'(m1), 16'(n)};
    p_idx = {fi, ei};
    p_rld = 16'(rld);
    p_lnk = lnk;
  endtask

  task automatic expect_block();
    bit whole, d2;
    int sz, n0, rld, frames, total;
    whole  = p_opt[0];
    d2     = p_opt[1];
    sz     = (p_opt[3:2] == 2'b01) ? 2 : (p_opt[3:2] == 2'b10) ? 1 : 4;
    n0     = int'(p_cnt[15:0]);
    frames = int'(p_cnt[31:16]) + 1;
    rld    = int'(p_rld);
    total  = n0 + (frames - 1) * rld;
    model_side(p_src, p_opt[5:4], d2, whole, sz, p_idx[15:0], p_idx[31:16], n0, rld, frames, q_src);
    model_side(p_dst, p_opt[7:6], d2, whole, sz, p_idx[15:0], p_idx[31:16], n0, rld, frames, q_dst);
    for (int i = 0; i < total; i++) q_sz.push_back(sz);
    if (!d2 && !whole) for (int i = 0; i < total; i++) q_burst.push_back(1);
    else if (d2 && whole) q_burst.push_back(total);
    else begin
      q_burst.push_back(n0);
      for (int f = 1; f < frames; f++) q_burst.push_back(rld);
    end
  endtask

  task automatic cfg_pulse();
    @(posedge clk); #2 cfg_load = 1;
    @(posedge clk); #2 cfg_load = 0;
  endtask

  task automatic play(input bit extra, input bit link_exp, input string tag);
    int target;
    target = popped;
    while (q_burst.size() > 0) begin
      bit last;
      target += q_burst.pop_front();
      last = (q_burst.size() == 0);
      @(posedge clk); #2 sync_ev = 1;
      @(posedge clk); #2;
      if (extra) begin
        @(posedge clk); #2;
      end
      sync_ev = 0;
      wait (popped >= target);
      @(negedge clk);
      chk(!out_vld, {tag, " burst ends after its unit"}, 64'(out_vld), 64'd0);
      chk(done == last, "R10 done at block end only", 64'(done), 64'(last));
      if (last) chk(lnk_req == link_exp, "R11 link request", 64'(lnk_req), 64'(link_exp));
    end
    @(negedge clk);
    chk(!done, "R10 done lasts one cycle", 64'(done), 64'd0);
    chk(popped == target, {tag, " no extra pairs"}, 64'(popped), 64'(target));
  endtask

  task automatic lone_event(input string req);
    @(posedge clk); #2 sync_ev = 1;
    @(posedge clk); #2 sync_ev = 0;
    @(negedge clk);
    chk(!out_vld, req, 64'(out_vld), 64'd0);
    @(negedge clk);
    chk(!out_vld, req, 64'(out_vld), 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk(!out_vld, "R1 reset no pair", 64'(out_vld), 64'd0);
    chk(!done, "R1 reset done low", 64'(done), 64'd0);
    chk(!lnk_req, "R1 reset no link request", 64'(lnk_req), 64'd0);
    lone_event("R1 event before load ignored");

    // R5: 1-D element sync, 8-bit, source increment, destination indexed
    set_bus(0, 0, 2'b10, 2'd1, 2'd3, 0, 32'h1000, 32'h2000, 3, 1, 16'd4, 16'd5, 3, 16'h0);
    expect_block();
    cfg_pulse();
    play(0, 0, "R5");
    lone_event("R11 unloaded after block without link");

    // R6: 1-D frame sync, 16-bit, source indexed, destination decrement, stalls, extra event, reload 2
    stall = 1;
    set_bus(1, 0, 2'b01, 2'd3, 2'd2, 0, 32'h3000, 32'h4000, 3, 2, 16'd4, 16'h0010, 2, 16'h0);
    expect_block();
    cfg_pulse();
    play(1, 0, "R6 R12 R4");
    stall = 0;

    // R7: 2-D line sync, 32-bit, source fixed, destination indexed (element index ignored)
    set_bus(0, 1, 2'b00, 2'd0, 2'd3, 0, 32'h5000, 32'h5800, 4, 1, 16'd100, 16'h0040, 4, 16'h0);
    expect_block();
    cfg_pulse();
    play(0, 0, "R7");

    // R8: 2-D block sync, reserved size code, source decrement, destination increment, linked
    set_bus(1, 1, 2'b11, 2'd2, 2'd1, 1, 32'h6000, 32'h7000, 2, 2, 16'd7, 16'd12, 2, 16'h0123);
    expect_block();
    cfg_pulse();
    play(0, 1, "R8");
    chk(lnk_addr == {LB, 16'h0123}, "R11 link address", 64'(lnk_addr), 64'({LB, 16'h0123}));
    chk(!out_vld, "R11 quiet while waiting for link", 64'(out_vld), 64'd0);

    // R11: serve the link with a 1-D frame-sync set, negative frame index
    set_bus(1, 0, 2'b10, 2'd1, 2'd1, 0, 32'h8000, 32'h9000, 2, 1, 16'd1, 16'hFFF0, 2, 16'h0);
    expect_block();
    @(posedge clk); #2 lnk_vld = 1;
    @(posedge clk); #2 lnk_vld = 0;
    @(negedge clk);
    chk(!lnk_req, "R11 link served", 64'(lnk_req), 64'd0);
    play(0, 0, "R11 R6");

    chk(q_src.size() == 0, "R4 all expected pairs seen", 64'(q_src.size()), 64'd0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule